// File: doc/BRIEF.md
# Serial Memory Slave Front-End with Transfer Pause

This block is the serial slave port of a small flash memory. A bus master selects it by pulling the active-low select line, then clocks command and data bytes in on one wire while the block answers on another. The block runs from the chip's system clock. It passes every serial input through a short synchronizer and finds the serial clock edges on the synchronized copy. The master therefore needs each serial clock phase to last at least `SYNC_STAGES + 2` system clock cycles. The block accepts the serial clock idle low (mode 0) or idle high (mode 3). It samples input on the rising edge and changes output on the falling edge. Bytes travel most significant bit first in both directions.

The first byte of each select frame is a command code. A code that the block knows is handed to the command handler together with a one-cycle strobe. Each later byte is handed over as a data byte with its own strobe. At every byte boundary after a known command, the block takes a return byte from the handler if the handler offers one, and shifts it out during the next byte time. An unknown command locks the port for the rest of the frame: nothing more is received and the output stays released until the select line falls again. A pause input lets the master freeze a transfer part way through a byte. The bit position and the partly shifted bytes survive the pause.

Top module: `spi_mem_front`

## Requirements
- R1: In both mode 0 and mode 3, the bit on `spiSi` at each rising `spiSck` edge is taken most significant bit first. Return data on `spiSo` changes only after falling `spiSck` edges and is valid at the next rising edge.
- R2: The first byte of a frame is the command code. The known codes are 0x01, 0x02, 0x03, 0x04, 0x05, 0x06, 0x0B and 0x9F. For a known code, `cmdValid` pulses for one cycle with the code on `cmdOp`, and `cmdOp` then holds the code until the frame ends.
- R3: Each complete byte after a known command appears on `dataByte` with a one-cycle `dataValid` pulse. `cmdValid` and `dataValid` never pulse in the same cycle.
- R4: At each byte boundary after a known command, if `txHave` is high, `txTake` pulses and `txData` is shifted out during the following byte time, most significant bit first, with `spiSoOe` high. If `txHave` is low, `spiSoOe` stays low for that byte. During the command byte `spiSoOe` is always low.
- R5: After an unknown command code, there is no `cmdValid`, no `dataValid` and no `txTake`, and `spiSoOe` stays low until `spiCsN` rises and falls again.
- R6: While `spiCsN` is high, `spiSoOe` is low, and `spiSck` and `spiSi` activity produces no strobe.
- R7: A rise of `spiCsN` at any point ends the frame. `cmdOp` returns to 0, a partly received byte is dropped, and the next frame starts again with a command byte.
- R8: A fall of `spiHoldN` while `spiSck` is low pauses the transfer. Until it is released, `spiSck` edges and `spiSi` are ignored and `spiSoOe` is low.
- R9: A rise of `spiHoldN` while `spiSck` is low resumes the transfer at the exact bit where it stopped. Received and returned bytes are the same as without the pause.
- R10: A change of `spiHoldN` while `spiSck` is high does not pause or resume the transfer.
- R11: After reset, `spiSoOe`, `cmdValid`, `dataValid`, `txTake` and `cmdOp` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiCsN | input | 1 | Serial select, active low |
| spiSck | input | 1 | Serial clock from the master |
| spiSi | input | 1 | Serial data into the block |
| spiHoldN | input | 1 | Transfer pause, active low |
| spiSo | output | 1 | Serial data out, meaningful while spiSoOe is high |
| spiSoOe | output | 1 | Output driver enable; low means the pad is high impedance |
| cmdValid | output | 1 | One-cycle strobe for an accepted command code |
| cmdOp | output | 8 | Accepted command code for the current frame |
| dataValid | output | 1 | One-cycle strobe for a received data byte |
| dataByte | output | 8 | Last received data byte |
| txHave | input | 1 | Handler has a return byte ready |
| txData | input | 8 | Return byte offered by the handler |
| txTake | output | 1 | One-cycle strobe: return byte taken |

## Verification
Frames are sent in both clock polarities, with known and unknown command codes, one to five data bytes, and the return source either present or absent. This separates sampling and shifting faults from decode and lock faults. Pauses are placed at random bit positions, including inside the command byte, while the serial clock and input keep toggling; an exact match of the bytes then shows that the bit position and the partly shifted state were kept. A pause line that falls and rises only during clock-high phases must leave the transfer untouched, which exposes a pause detector that ignores the clock level. Aborted frames and clock noise while deselected show that stale bits and codes do not carry into the next frame.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPC  = 2'd1,
    ST_DATA = 2'd2,
    ST_LOCK = 2'd3
  } frameSt_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;     // drop all frame state
    logic shiftIn;   // take one serial input bit
    logic lastIn;    // this input bit completes a byte
    logic latchOp;   // completed byte is a known command
    logic loadTx;    // byte boundary: offer to load a return byte
    logic shiftOut;  // present next return bit
  } dpCtl_t;

  function automatic logic opKnown(input logic [BYTE_W-1:0] op);
    case (op)
      8'h01, 8'h02, 8'h03, 8'h04,
      8'h05, 8'h06, 8'h0B, 8'h9F: return 1'b1;
      default:                    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csNS,
  input  logic              sckS,
  input  logic              holdNS,
  input  logic              lastBit,
  input  logic [BYTE_W-1:0] rxNext,
  output dpCtl_t            ctl,
  output logic              outAllow,
  output logic              cmdValid,
  output logic              dataValid,
  output logic              held,
  output logic              stLock
);

  frameSt_t state, stateNxt;
  logic     sckPrev, holdPrev;
  logic     heldNxt;
  logic     csSel, sckRise, sckFall, holdFall, holdRise, running;

  assign csSel    = !csNS;
  assign sckRise  = sckS & !sckPrev;
  assign sckFall  = !sckS & sckPrev;
  assign holdFall = holdPrev & !holdNS;
  assign holdRise = !holdPrev & holdNS;
  assign running  = csSel && !held && ((state == ST_OPC) || (state == ST_DATA));

  // strobes
  always_comb begin
    ctl          = '0;
    ctl.clear    = !csSel;
    ctl.shiftIn  = running && sckRise;
    ctl.lastIn   = ctl.shiftIn && lastBit;
    ctl.latchOp  = ctl.lastIn && (state == ST_OPC) && opKnown(rxNext);
    ctl.loadTx   = ctl.lastIn && ((state == ST_DATA) || ctl.latchOp);
    ctl.shiftOut = running && (state == ST_DATA) && sckFall;
  end

  // pause tracking: edges count only while the serial clock is low
  always_comb begin
    heldNxt = held;
    if (!csSel)                   heldNxt = 1'b0;
    else if (holdFall && !sckS)   heldNxt = 1'b1;
    else if (holdRise && !sckS)   heldNxt = 1'b0;
  end

  always_comb begin
    stateNxt = state;
    if (!csSel) begin
      stateNxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: stateNxt = ST_OPC;
        ST_OPC:  if (ctl.lastIn) stateNxt = ctl.latchOp ? ST_DATA : ST_LOCK;
        default: stateNxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sckPrev   <= 1'b0;
      holdPrev  <= 1'b1;
      held      <= 1'b0;
      cmdValid  <= 1'b0;
      dataValid <= 1'b0;
    end else begin
      state     <= stateNxt;
      sckPrev   <= sckS;
      holdPrev  <= holdNS;
      held      <= heldNxt;
      cmdValid  <= ctl.latchOp;
      dataValid <= ctl.lastIn && (state == ST_DATA);
    end
  end

  assign outAllow = csSel && !held && (state == ST_DATA);
  assign stLock   = (state == ST_LOCK);

endmodule

// File: rtl/spi_mem_dp.sv
module spi_mem_dp
  import spi_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              siS,
  input  logic              txHave,
  input  logic [BYTE_W-1:0] txData,
  output logic              lastBit,
  output logic [BYTE_W-1:0] rxNext,
  output logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] opReg,
  output logic              soBit,
  output logic              txActive,
  output logic [CNT_W-1:0]  bitCnt
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] rxShift, txShift;

  assign lastBit = (bitCnt == LAST_IDX);
  assign rxNext  = {rxShift[BYTE_W-2:0], siS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      rxByte   <= '0;
      opReg    <= '0;
      txShift  <= '0;
      txActive <= 1'b0;
      soBit    <= 1'b0;
    end else if (ctl.clear) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      opReg    <= '0;
      txShift  <= '0;
      txActive <= 1'b0;
      soBit    <= 1'b0;
    end else begin
      if (ctl.shiftIn) begin
        rxShift <= rxNext;
        bitCnt  <= lastBit ? '0 : bitCnt + 1'b1;
      end
      if (ctl.lastIn)  rxByte <= rxNext;
      if (ctl.latchOp) opReg  <= rxNext;
      if (ctl.loadTx) begin
        txShift  <= txData;
        txActive <= txHave;
      end else if (ctl.shiftOut && txActive) begin
        soBit   <= txShift[BYTE_W-1];
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
  import spi_mem_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiCsN,
  input  logic              spiSck,
  input  logic              spiSi,
  input  logic              spiHoldN,
  output logic              spiSo,
  output logic              spiSoOe,
  output logic              cmdValid,
  output logic [BYTE_W-1:0] cmdOp,
  output logic              dataValid,
  output logic [BYTE_W-1:0] dataByte,
  input  logic              txHave,
  input  logic [BYTE_W-1:0] txData,
  output logic              txTake
);

  localparam int unsigned PIN_N = 4;

  logic [PIN_N-1:0] pinRaw, pinSync;
  logic csNS, sckS, holdNS, siS;
  dpCtl_t ctl;
  logic lastBit, outAllow, held, stLock, soBit, txActive, csSel;
  logic [BYTE_W-1:0] rxNext;
  logic [CNT_W-1:0]  dpBitCnt;

  assign pinRaw = {spiCsN, spiHoldN, spiSck, spiSi};

  spi_mem_sync #(
    .WIDTH  (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b1100)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (pinRaw),
    .dout(pinSync)
  );

  assign {csNS, holdNS, sckS, siS} = pinSync;
  assign csSel = !csNS;

  spi_mem_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csNS     (csNS),
    .sckS     (sckS),
    .holdNS   (holdNS),
    .lastBit  (lastBit),
    .rxNext   (rxNext),
    .ctl      (ctl),
    .outAllow (outAllow),
    .cmdValid (cmdValid),
    .dataValid(dataValid),
    .held     (held),
    .stLock   (stLock)
  );

  spi_mem_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .siS     (siS),
    .txHave  (txHave),
    .txData  (txData),
    .lastBit (lastBit),
    .rxNext  (rxNext),
    .rxByte  (dataByte),
    .opReg   (cmdOp),
    .soBit   (soBit),
    .txActive(txActive),
    .bitCnt  (dpBitCnt)
  );

  assign spiSoOe = outAllow & txActive;
  assign spiSo   = spiSoOe & soBit;
  assign txTake  = ctl.loadTx & txHave;

endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk
  import spi_mem_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              spiSoOe,
  input logic              csSel,
  input logic              held,
  input logic              stLock,
  input logic              cmdValid,
  input logic              dataValid,
  input logic              txTake,
  input logic [BYTE_W-1:0] cmdOp,
  input logic [CNT_W-1:0]  bitCnt
);

  p_oe_needs_sel_r6: assert property (@(posedge clk) disable iff (!rstN)
    spiSoOe |-> csSel);

  p_oe_off_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    spiSoOe |-> !held);

  p_lock_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    stLock |-> (!spiSoOe && !dataValid && !cmdValid && !txTake));

  p_op_known_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> opKnown(cmdOp));

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && dataValid));

  p_cnt_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (held && $past(held)) |-> $stable(bitCnt));

  p_abort_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    !csSel |=> (bitCnt == '0 && cmdOp == '0));

endmodule

bind spi_mem_front spi_mem_front_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .spiSoOe  (spiSoOe),
  .csSel    (csSel),
  .held     (held),
  .stLock   (stLock),
  .cmdValid (cmdValid),
  .dataValid(dataValid),
  .txTake   (txTake),
  .cmdOp    (cmdOp),
  .bitCnt   (dpBitCnt)
);

// File: tb/sim_spi_mem_front.sv
module sim_spi_mem_front;

  localparam int H = 8;  // system clocks per serial clock phase

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, si = 1'b0, holdN = 1'b1, txHave = 1'b0;
  logic [7:0] txData;
  logic spiSo, spiSoOe, cmdValid, dataValid, txTake;
  logic [7:0] cmdOp, dataByte;

  int nChk = 0, nBad = 0, cyc = 0;
  int rxCnt = 0, opSeen = 0, takeCnt = 0;
  logic [7:0] lastOp = 8'h00;
  logic [7:0] rxLog [0:63];
  bit glitchPend = 1'b0;

  always #4 clk = ~clk;

  spi_mem_front u0 (
    .clk(clk), .rstN(rstN), .spiCsN(csN), .spiSck(sck), .spiSi(si),
    .spiHoldN(holdN), .spiSo(spiSo), .spiSoOe(spiSoOe),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .dataValid(dataValid),
    .dataByte(dataByte), .txHave(txHave), .txData(txData), .txTake(txTake)
  );

  function automatic logic [7:0] patByte(input int n);
    return 8'((n * 37) + 11) ^ 8'h5A;
  endfunction

  function automatic bit knownOp(input logic [7:0] op);
    logic [7:0] lst [8] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h0B, 8'h9F};
    for (int i = 0; i < 8; i++) if (lst[i] == op) return 1'b1;
    return 1'b0;
  endfunction

  assign txData = patByte(takeCnt);

  // handler model and monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (cmdValid) begin opSeen <= opSeen + 1; lastOp <= cmdOp; end
      if (dataValid) begin rxLog[rxCnt & 63] <= dataByte; rxCnt <= rxCnt + 1; end
      if (txTake) takeCnt <= takeCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial bit: low phase, optional pause, sample, high phase
  task automatic xferBit(input logic b, input bit doHold, input bit glitch,
                         output logic soVal, output logic oeVal);
    sck = 1'b0; si = b;
    waitClk(H);
    if (doHold) begin
      holdN = 1'b0;
      waitClk(H);
      for (int i = 0; i < 3; i++) begin
        sck = 1'b1; si = 1'($urandom); waitClk(H);
        sck = 1'b0; si = 1'($urandom); waitClk(H);
      end
      chk(spiSoOe == 1'b0, "R8 output released while paused", spiSoOe, 0);
      si = b; holdN = 1'b1;
      waitClk(H);
    end
    soVal = spiSo; oeVal = spiSoOe;
    sck = 1'b1;
    waitClk(3);
    if (glitch) holdN = 1'b0;
    else if (glitchPend) holdN = 1'b1;
    glitchPend = glitch;
    waitClk(H - 3);
  endtask

  task automatic runFrame(input bit mode3, input logic [7:0] op, input int nData,
                          input bit have, input int holdBit, input int glitchBit);
    logic [7:0] dat [0:7];
    int rx0, op0, take0;
    bit known;
    logic s, o;
    sck = mode3; holdN = 1'b1; txHave = have;
    waitClk(2 * H);
    rx0 = rxCnt; op0 = opSeen; take0 = takeCnt;
    known = knownOp(op);
    for (int k = 0; k < nData; k++) dat[k] = 8'($urandom);
    csN = 1'b0;
    waitClk(H);
    for (int k = 0; k <= nData; k++) begin
      logic [7:0] val, got;
      bit expOe, oeOk;
      val = (k == 0) ? op : dat[k-1];
      expOe = known && have && (k >= 1);
      got = '0; oeOk = 1'b1;
      for (int b = 7; b >= 0; b--) begin
        int idx;
        idx = k * 8 + (7 - b);
        xferBit(val[b], idx == holdBit, idx == glitchBit, s, o);
        got = {got[6:0], s};
        if (o != expOe) oeOk = 1'b0;
      end
      chk(oeOk, known ? "R4 output enable per byte" : "R5 output stays released", oeOk, 1);
      if (expOe)
        chk(got == patByte(take0 + k - 1),
            (holdBit >= 0) ? "R9 return byte across pause" :
            (glitchBit >= 0) ? "R10 return byte with high-phase pause line" :
            "R1/R4 return byte", got, patByte(take0 + k - 1));
    end
    waitClk(H);
    if (!mode3) sck = 1'b0;
    waitClk(H);
    chk(opSeen - op0 == (known ? 1 : 0), known ? "R2 command strobe count" : "R5 no command strobe",
        opSeen - op0, known ? 1 : 0);
    if (known) chk(lastOp == op, "R2 command code", lastOp, op);
    if (known) chk(cmdOp == op, "R2 code held in frame", cmdOp, op);
    chk(rxCnt - rx0 == (known ? nData : 0), known ? "R3 data strobe count" : "R5 no data strobe",
        rxCnt - rx0, known ? nData : 0);
    if (known)
      for (int k = 0; k < nData; k++)
        chk(rxLog[(rx0 + k) & 63] == dat[k],
            (holdBit >= 0) ? "R9 received byte across pause" :
            (glitchBit >= 0) ? "R10 received byte with high-phase pause line" :
            "R1/R3 received byte", rxLog[(rx0 + k) & 63], dat[k]);
    if (!known) chk(takeCnt == take0, "R5 no return take", takeCnt - take0, 0);
    csN = 1'b1;
    waitClk(3 * H);
    chk(cmdOp == 8'h00, "R7 code cleared at deselect", cmdOp, 0);
    chk(spiSoOe == 1'b0, "R6 released when deselected", spiSoOe, 0);
  endtask

  // frame cut short by a rise of select part way through a byte
  task automatic abortFrame(input bit mode3, input logic [7:0] op, input int extraBits);
    int rx0;
    logic s, o;
    sck = mode3; txHave = 1'b1;
    waitClk(2 * H);
    csN = 1'b0;
    waitClk(H);
    for (int b = 7; b >= 0; b--) xferBit(op[b], 1'b0, 1'b0, s, o);
    rx0 = rxCnt;
    for (int b = 0; b < extraBits; b++) xferBit(1'($urandom), 1'b0, 1'b0, s, o);
    waitClk(H);
    csN = 1'b1;
    waitClk(3 * H);
    chk(cmdOp == 8'h00, "R7 code cleared on abort", cmdOp, 0);
    chk(rxCnt == rx0, "R7 partial byte dropped", rxCnt - rx0, 0);
  endtask

  task automatic deselNoise();
    int rx0, op0, take0;
    bit oeSeen;
    rx0 = rxCnt; op0 = opSeen; take0 = takeCnt; oeSeen = 1'b0;
    csN = 1'b1;
    for (int i = 0; i < 20; i++) begin
      sck = ~sck; si = 1'($urandom);
      waitClk(H);
      if (spiSoOe) oeSeen = 1'b1;
    end
    chk(!oeSeen, "R6 no drive while deselected", oeSeen, 0);
    chk((rxCnt == rx0) && (opSeen == op0) && (takeCnt == take0),
        "R6 no strobes while deselected", rxCnt - rx0 + opSeen - op0, 0);
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 190000) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual=%0d expected<=190000", cyc);
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [7:0] knownList [8] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h0B, 8'h9F};
    void'($urandom(32'h1F3A));
    waitClk(5);
    chk(spiSoOe == 1'b0 && cmdValid == 1'b0 && dataValid == 1'b0 && txTake == 1'b0,
        "R11 strobes low in reset", {spiSoOe, cmdValid, dataValid, txTake}, 0);
    rstN = 1'b1;
    waitClk(5);
    chk(cmdOp == 8'h00 && spiSoOe == 1'b0, "R11 idle after reset", {cmdOp, spiSoOe}, 0);

    // directed cases
    runFrame(1'b0, 8'h03, 3, 1'b1, -1, -1);   // mode 0 with return
    runFrame(1'b1, 8'h0B, 3, 1'b1, -1, -1);   // mode 3 with return
    runFrame(1'b0, 8'h02, 2, 1'b0, -1, -1);   // no return byte offered
    runFrame(1'b0, 8'hFF, 2, 1'b1, -1, -1);   // unknown code, mode 0
    runFrame(1'b1, 8'h00, 3, 1'b1, -1, -1);   // unknown code, mode 3
    runFrame(1'b0, 8'h05, 1, 1'b1, -1, -1);   // relock cleared by new frame
    runFrame(1'b0, 8'h03, 3, 1'b1, 12, -1);   // pause mid data byte
    runFrame(1'b1, 8'h9F, 2, 1'b1, 3, -1);    // pause inside command byte
    runFrame(1'b1, 8'h01, 2, 1'b1, 21, -1);   // pause late, mode 3
    runFrame(1'b0, 8'h06, 3, 1'b1, -1, 10);   // pause line moves in high phases
    runFrame(1'b1, 8'h03, 2, 1'b1, -1, 5);
    abortFrame(1'b0, 8'h03, 5);
    runFrame(1'b0, 8'h04, 2, 1'b1, -1, -1);
    abortFrame(1'b1, 8'h02, 3);
    deselNoise();
    runFrame(1'b1, 8'h03, 2, 1'b1, -1, -1);

    // constrained random frames
    for (int f = 0; f < 30; f++) begin
      bit m3, hv;
      int nd, hb, gb;
      logic [7:0] op;
      m3 = 1'($urandom);
      hv = ($urandom % 4) != 0;
      nd = 1 + ($urandom % 5);
      op = (($urandom % 4) == 0) ? 8'($urandom) : knownList[$urandom % 8];
      hb = -1; gb = -1;
      case ($urandom % 3)
        0: hb = int'($urandom % ((nd + 1) * 8));
        1: gb = int'($urandom % ((nd + 1) * 8 - 1));
        default: ;
      endcase
      runFrame(m3, op, nd, hv, hb, gb);
      if ((f % 10) == 9) deselNoise();
    end

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule